// File: doc/BRIEF.md
# Prioritised Reset Source Sequencer

This block collects five reset requests (power-on, the external reset pin, low-voltage, clock-monitor failure and watchdog timeout) and turns them into one chip-level reset. While the chip runs it watches the requests. The highest-ranked one wins, and the block records a vector address that depends on the winner's priority class. It then runs a clocked sequence. First it pulls the open-drain reset pin low for a fixed number of cycles. It then releases the pin and waits for the pin to be seen high again. Only after that does it let normal processing resume.

The external pin is both a request and an output. It passes through a synchroniser before arbitration. If the pin stays low for a full check window after the block releases it, an outside agent is holding it. The reset is then reclassified as an external reset. On the cycle the internal reset ends, the block captures three mode-select straps and a flash-visibility strap. It also keeps sticky cause flags that only power-on clears by itself.

Top module: `reset_sequencer`

## Requirements
- R1: While `por` is high, `sys_rst` and `rst_pin_drive_low` are 1 and `vector_addr` is 0xFFFE. The first clock after `por` falls leaves `cause_flags` at 5'b00001. Flag bits are: 0 power-on, 1 external pin, 2 low-voltage, 3 clock-monitor, 4 watchdog.
- R2: A low-voltage request or a synchronised low external pin starts a reset with `vector_addr` 0xFFFE. It sets flag bit 2 or bit 1 respectively, or both if both are present.
- R3: A clock-monitor request with no top-class request present starts a reset with `vector_addr` 0xFFFC and sets flag bit 3.
- R4: A watchdog request with no other request present starts a reset with `vector_addr` 0xFFFA and sets flag bit 4.
- R5: When requests of different classes arrive in the same cycle, only the highest class is taken. The lower sources leave their flag bits unchanged.
- R6: Each reset drives `rst_pin_drive_low` for exactly DRIVE_LEN cycles (default 16). Requests are only arbitrated while `sys_rst` is 0. `sys_rst` stays 1 until the synchronised pin reads high.
- R7: If the synchronised pin is still low CHECK_WIN cycles (default 32) after release, `vector_addr` becomes 0xFFFE and flag bit 1 is set. `sys_rst` then stays 1 until the pin is seen high.
- R8: On the cycle the reset sequence ends, `mode_pins` is copied into `mode_bits` and `flash_ctl_pin` is copied into `flash_visible` (1 means flash is mapped). Both outputs hold while the chip runs.
- R9: Cause flags are sticky. A 1 in `cause_clr` clears the matching flag on the next clock. Non-power-on resets never clear a flag.
- R10: The external pin is sampled through two flops. A low level applied after one clock edge raises `sys_rst` after the third following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por | input | 1 | Power-on reset request, synchronous, active high |
| lvr_req | input | 1 | Low-voltage reset request from the regulator |
| cm_req | input | 1 | Clock-monitor failure request |
| wdog_req | input | 1 | Watchdog timeout request |
| rst_pin_in | input | 1 | Level seen on the bidirectional reset pin |
| mode_pins | input | 3 | Mode-select strap levels |
| flash_ctl_pin | input | 1 | Flash-visibility strap level |
| cause_clr | input | 5 | Write-one-to-clear strobe for the cause flags |
| rst_pin_drive_low | output | 1 | Open-drain enable pulling the reset pin low |
| sys_rst | output | 1 | Internal chip reset, active high |
| vector_addr | output | 16 | Reset vector address of the winning class |
| mode_bits | output | 3 | Latched mode straps |
| flash_visible | output | 1 | Latched flash-visibility strap |
| cause_flags | output | 5 | Sticky reset cause flags |

## Verification
The hardest case to reach is the release-and-recheck path. The block has already released the pin, and something outside keeps it low for the whole check window. The bench models the board as a wired-AND of the block's drive and a hold signal of its own. It raises that hold together with a watchdog request and keeps it up past DRIVE_LEN plus CHECK_WIN cycles. The bench then checks that the vector is reclassified and the external flag is set, and that reset ends only after the hold is removed. Same-cycle requests of different classes are applied on a single clock to show that the lower flag stays clear.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int NUM_SRC = 5;
    localparam int MODE_W  = 3;

    // flag bit positions
    localparam int F_POR = 0;
    localparam int F_EXT = 1;
    localparam int F_LVR = 2;
    localparam int F_CM  = 3;
    localparam int F_WD  = 4;

    typedef enum logic [1:0] {
        CLS_TOP  = 2'd0,
        CLS_CLK  = 2'd1,
        CLS_WDOG = 2'd2
    } rst_class_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_DRIVE   = 2'd1,
        ST_RELEASE = 2'd2,
        ST_HELD    = 2'd3
    } seq_state_e;

    typedef struct packed {
        logic                 valid;
        rst_class_e           cls;
        logic [NUM_SRC-1:0]   set_mask;
    } arb_result_t;

    function automatic logic [15:0] vector_of(rst_class_e c);
        case (c)
            CLS_CLK:  return 16'hFFFC;
            CLS_WDOG: return 16'hFFFA;
            default:  return 16'hFFFE;
        endcase
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] stage_q;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (por) begin
                    stage_q[g] <= 1'b1;
                end else if (g == 0) begin
                    stage_q[g] <= d_in;
                end else begin
                    stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign q_out = stage_q[STAGES-1];
endmodule

// File: rtl/rstseq_arb.sv
module rstseq_arb
    import rstseq_pkg::*;
(
    input  logic        ext_low,
    input  logic        lvr_req,
    input  logic        cm_req,
    input  logic        wdog_req,
    output arb_result_t result
);
    always_comb begin
        result          = '0;
        result.cls      = CLS_TOP;
        if (ext_low || lvr_req) begin
            result.valid           = 1'b1;
            result.cls             = CLS_TOP;
            result.set_mask[F_EXT] = ext_low;
            result.set_mask[F_LVR] = lvr_req;
        end else if (cm_req) begin
            result.valid           = 1'b1;
            result.cls             = CLS_CLK;
            result.set_mask[F_CM]  = 1'b1;
        end else if (wdog_req) begin
            result.valid           = 1'b1;
            result.cls             = CLS_WDOG;
            result.set_mask[F_WD]  = 1'b1;
        end
    end
endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int DRIVE_LEN = 16,
    parameter int CHECK_WIN = 32
) (
    input  logic       clk,
    input  logic       por,
    input  logic       req_valid,
    input  logic       pin_high,
    output seq_state_e state_o,
    output logic       start_o,
    output logic       timeout_o,
    output logic       done_o
);
    localparam int MAXC  = (DRIVE_LEN > CHECK_WIN) ? DRIVE_LEN : CHECK_WIN;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] DRV_LAST = CNT_W'(DRIVE_LEN - 1);
    localparam logic [CNT_W-1:0] WIN_LAST = CNT_W'(CHECK_WIN - 1);

    seq_state_e       state_q, state_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;

    always_comb begin
        state_n   = state_q;
        cnt_n     = cnt_q;
        start_o   = 1'b0;
        timeout_o = 1'b0;
        done_o    = 1'b0;
        case (state_q)
            ST_RUN: begin
                if (req_valid) begin
                    start_o = 1'b1;
                    state_n = ST_DRIVE;
                    cnt_n   = '0;
                end
            end
            ST_DRIVE: begin
                if (cnt_q == DRV_LAST) begin
                    state_n = ST_RELEASE;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            ST_RELEASE: begin
                if (pin_high) begin
                    done_o  = 1'b1;
                    state_n = ST_RUN;
                end else if (cnt_q == WIN_LAST) begin
                    timeout_o = 1'b1;
                    state_n   = ST_HELD;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            default: begin
                if (pin_high) begin
                    done_o  = 1'b1;
                    state_n = ST_RUN;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (por) begin
            state_q <= ST_DRIVE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer
    import rstseq_pkg::*;
#(
    parameter int DRIVE_LEN   = 16,
    parameter int CHECK_WIN   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por,
    input  logic                lvr_req,
    input  logic                cm_req,
    input  logic                wdog_req,
    input  logic                rst_pin_in,
    input  logic [MODE_W-1:0]   mode_pins,
    input  logic                flash_ctl_pin,
    input  logic [NUM_SRC-1:0]  cause_clr,
    output logic                rst_pin_drive_low,
    output logic                sys_rst,
    output logic [15:0]         vector_addr,
    output logic [MODE_W-1:0]   mode_bits,
    output logic                flash_visible,
    output logic [NUM_SRC-1:0]  cause_flags
);
    logic        pin_high_s;
    arb_result_t arb;
    seq_state_e  state;
    logic        start, timeout, done;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .por   (por),
        .d_in  (rst_pin_in),
        .q_out (pin_high_s)
    );

    rstseq_arb u_arb (
        .ext_low  (!pin_high_s),
        .lvr_req  (lvr_req),
        .cm_req   (cm_req),
        .wdog_req (wdog_req),
        .result   (arb)
    );

    rstseq_fsm #(.DRIVE_LEN(DRIVE_LEN), .CHECK_WIN(CHECK_WIN)) u_fsm (
        .clk       (clk),
        .por       (por),
        .req_valid (arb.valid),
        .pin_high  (pin_high_s),
        .state_o   (state),
        .start_o   (start),
        .timeout_o (timeout),
        .done_o    (done)
    );

    rst_class_e         cls_q;
    logic [NUM_SRC-1:0] flags_q, set_now;
    logic [MODE_W-1:0]  mode_q;
    logic               flash_q;

    always_comb begin
        set_now = '0;
        if (start)   set_now = set_now | arb.set_mask;
        if (timeout) set_now[F_EXT] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (por) begin
            cls_q   <= CLS_TOP;
            flags_q <= NUM_SRC'(1) << F_POR;
            mode_q  <= '0;
            flash_q <= 1'b0;
        end else begin
            if (start)        cls_q <= arb.cls;
            else if (timeout) cls_q <= CLS_TOP;
            flags_q <= (flags_q & ~cause_clr) | set_now;
            if (done) begin
                mode_q  <= mode_pins;
                flash_q <= flash_ctl_pin;
            end
        end
    end

    assign sys_rst           = (state != ST_RUN);
    assign rst_pin_drive_low = (state == ST_DRIVE);
    assign vector_addr       = vector_of(cls_q);
    assign mode_bits         = mode_q;
    assign flash_visible     = flash_q;
    assign cause_flags       = flags_q;
endmodule

// File: rtl/reset_sequencer_chk.sv
module reset_sequencer_chk (
    input logic        clk,
    input logic        por,
    input logic        sys_rst,
    input logic        rst_pin_drive_low,
    input logic [15:0] vector_addr,
    input logic [2:0]  mode_bits,
    input logic [4:0]  cause_flags,
    input logic [4:0]  cause_clr
);
    logic armed;
    always_ff @(posedge clk) begin
        if (por) armed <= 1'b1;
    end

    // R6
    drive_in_reset_chk: assert property (@(posedge clk) disable iff (por)
        (armed && rst_pin_drive_low) |-> sys_rst);

    // R2
    vector_legal_chk: assert property (@(posedge clk) disable iff (por)
        armed |-> (vector_addr == 16'hFFFE || vector_addr == 16'hFFFC || vector_addr == 16'hFFFA));

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (por)
        (armed && !sys_rst && !$past(sys_rst) && !$past(por)) |-> $stable(mode_bits));

    // R9
    flags_sticky_chk: assert property (@(posedge clk) disable iff (por)
        (armed && !$past(por)) |-> ((cause_flags & ($past(cause_flags) & ~$past(cause_clr)))
                                     == ($past(cause_flags) & ~$past(cause_clr))));

    // R1
    por_exit_chk: assert property (@(posedge clk) disable iff (por)
        (armed && $past(por)) |-> (sys_rst && rst_pin_drive_low && vector_addr == 16'hFFFE
                                   && cause_flags == 5'b00001));
endmodule

bind reset_sequencer reset_sequencer_chk u_chk (
    .clk               (clk),
    .por               (por),
    .sys_rst           (sys_rst),
    .rst_pin_drive_low (rst_pin_drive_low),
    .vector_addr       (vector_addr),
    .mode_bits         (mode_bits),
    .cause_flags       (cause_flags),
    .cause_clr         (cause_clr)
);

// File: tb/reset_sequencer_bench.sv
`timescale 1ns/1ps
module reset_sequencer_bench;
    localparam int DRV = 16;
    localparam int WIN = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       por = 1'b1, lvr_req = 1'b0, cm_req = 1'b0, wdog_req = 1'b0;
    logic       ext_hold = 1'b0, flash_ctl_pin = 1'b0;
    logic [2:0] mode_pins = 3'b000;
    logic [4:0] cause_clr = 5'b0;
    logic       rst_pin_in, rst_pin_drive_low, sys_rst, flash_visible;
    logic [15:0] vector_addr;
    logic [2:0]  mode_bits;
    logic [4:0]  cause_flags;

    assign rst_pin_in = !(rst_pin_drive_low || ext_hold);

    reset_sequencer #(.DRIVE_LEN(DRV), .CHECK_WIN(WIN)) u_reset_sequencer (
        .clk(clk), .por(por), .lvr_req(lvr_req), .cm_req(cm_req), .wdog_req(wdog_req),
        .rst_pin_in(rst_pin_in), .mode_pins(mode_pins), .flash_ctl_pin(flash_ctl_pin),
        .cause_clr(cause_clr), .rst_pin_drive_low(rst_pin_drive_low), .sys_rst(sys_rst),
        .vector_addr(vector_addr), .mode_bits(mode_bits), .flash_visible(flash_visible),
        .cause_flags(cause_flags)
    );

    int vectors = 0, errors = 0, cycles = 0;
    bit model_ok = 1'b0;

    // behavioural reference
    int   m_ph = 1, m_cnt = 0;
    int   m_vec = 'hFFFE;
    bit [4:0] m_flags = 5'b00001;
    bit [2:0] m_mode = 0;
    bit   m_fl = 0, s1 = 1, s2 = 1;

    always @(posedge clk) begin
        bit pin_m;
        pin_m = !((m_ph == 1) || ext_hold);
        if (por) begin
            m_ph = 1; m_cnt = 0; m_vec = 'hFFFE; m_flags = 5'b00001;
            m_mode = 0; m_fl = 0; s1 = 1; s2 = 1; model_ok = 1'b1;
        end else begin
            bit [4:0] setb;
            setb = 0;
            if (m_ph == 0) begin
                if (lvr_req || !s2) begin
                    m_vec = 'hFFFE; setb[2] = lvr_req; setb[1] = !s2; m_ph = 1; m_cnt = 0;
                end else if (cm_req) begin
                    m_vec = 'hFFFC; setb[3] = 1; m_ph = 1; m_cnt = 0;
                end else if (wdog_req) begin
                    m_vec = 'hFFFA; setb[4] = 1; m_ph = 1; m_cnt = 0;
                end
            end else if (m_ph == 1) begin
                if (m_cnt == DRV - 1) begin m_ph = 2; m_cnt = 0; end
                else m_cnt++;
            end else begin
                if (s2) begin
                    m_ph = 0; m_mode = mode_pins; m_fl = flash_ctl_pin;
                end else if (m_ph == 2) begin
                    if (m_cnt == WIN - 1) begin m_ph = 3; m_vec = 'hFFFE; setb[1] = 1; end
                    else m_cnt++;
                end
            end
            m_flags = (m_flags & ~cause_clr) | setb;
            s2 = s1; s1 = pin_m;
        end
    end

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cycles++;
        if (model_ok) begin
            cmp("R6", "sys_rst", sys_rst, (m_ph != 0));
            cmp("R6", "drive_low", rst_pin_drive_low, (m_ph == 1));
            cmp("R5", "vector", vector_addr, m_vec);
            cmp("R9", "flags", cause_flags, m_flags);
            cmp("R8", "mode", mode_bits, m_mode);
            cmp("R8", "flash", flash_visible, m_fl);
        end
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_run();
        int guard = 0;
        do begin @(negedge clk); guard++; end while (sys_rst && guard < 500);
    endtask

    task automatic pulse_req(input bit l, input bit c, input bit w);
        lvr_req = l; cm_req = c; wdog_req = w;
        step(1);
        lvr_req = 0; cm_req = 0; wdog_req = 0;
    endtask

    initial begin
        mode_pins = 3'b101; flash_ctl_pin = 1'b1;
        step(3);
        // R1: state during power-on
        cmp("R1", "por sys_rst", sys_rst, 1);
        cmp("R1", "por drive", rst_pin_drive_low, 1);
        por = 1'b0;
        step(1);
        cmp("R1", "por flags", cause_flags, 5'b00001);
        wait_run();
        // R8: straps latched at exit
        cmp("R8", "mode latched", mode_bits, 3'b101);
        cmp("R8", "flash latched", flash_visible, 1);
        // R8: strap change while running has no effect
        mode_pins = 3'b010; flash_ctl_pin = 1'b0;
        step(5);
        cmp("R8", "mode held", mode_bits, 3'b101);
        // R9: write-one-to-clear
        cause_clr = 5'b00001; step(1); cause_clr = 0;
        cmp("R9", "cleared", cause_flags, 5'b00000);
        // R4: watchdog alone
        pulse_req(0, 0, 1);
        cmp("R4", "vector", vector_addr, 16'hFFFA);
        cmp("R4", "flag", cause_flags, 5'b10000);
        wait_run();
        cmp("R8", "mode relatched", mode_bits, 3'b010);
        cmp("R8", "flash relatched", flash_visible, 0);
        // R3 + R5: clock monitor beats watchdog
        cause_clr = 5'b11111; step(1); cause_clr = 0;
        pulse_req(0, 1, 1);
        cmp("R3", "vector", vector_addr, 16'hFFFC);
        cmp("R5", "wd flag untouched", cause_flags, 5'b01000);
        wait_run();
        // R2 + R5: low-voltage beats clock monitor
        cause_clr = 5'b11111; step(1); cause_clr = 0;
        pulse_req(1, 1, 0);
        cmp("R2", "vector", vector_addr, 16'hFFFE);
        cmp("R5", "cm flag untouched", cause_flags, 5'b00100);
        wait_run();
        // R9: non-power-on reset keeps earlier flags
        pulse_req(0, 0, 1);
        cmp("R9", "accumulate", cause_flags, 5'b10100);
        wait_run();
        // R10 + R2: external pin through synchroniser
        ext_hold = 1'b1;
        step(2);
        cmp("R10", "not yet", sys_rst, 0);
        step(1);
        cmp("R10", "entered", sys_rst, 1);
        cmp("R2", "ext flag", cause_flags[1], 1);
        step(3); ext_hold = 1'b0;
        wait_run();
        // R7: pin held low beyond check window
        cause_clr = 5'b11111; step(1); cause_clr = 0;
        ext_hold = 1'b1;
        pulse_req(0, 0, 1);
        cmp("R7", "initial vector", vector_addr, 16'hFFFA);
        step(DRV + WIN + 10);
        cmp("R7", "still held", sys_rst, 1);
        cmp("R7", "reclassified", vector_addr, 16'hFFFE);
        cmp("R7", "ext flag", cause_flags[1], 1);
        ext_hold = 1'b0;
        wait_run();
        cmp("R7", "released", sys_rst, 0);
        // R6: level request holds through sequence, rearbitrates after
        lvr_req = 1'b1; step(DRV + 2); lvr_req = 1'b0;
        wait_run();
        step(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule